// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block watches a running clock's minutes, hours and day-of-week values and raises an alarm when they agree with three programmed alarm bytes. Bit 7 of each alarm byte is a "don't care" bit that drops its field from the comparison. Setting these bits in a chain from the day byte downwards gives a weekly, daily, hourly or once-per-minute alarm. The comparison is taken only at the instant the timekeeping chain signals a seconds rollover on the last hundredths step. At that instant the time inputs already show the newly incremented time.

Software reaches the block through a byte-wide register port with four locations: minute alarm (select 0), hour alarm (select 1), day alarm (select 2) and control/status (select 3). In the control/status byte, bit 0 is the read-only alarm flag and bit 1 is the interrupt mask. Read data is combinational on the select lines. A location counts as accessed only when the read or write strobe is high. A read or write strobe on any alarm byte clears the flag. The interrupt request is a registered copy of the flag, gated by the mask.

Top module: `tod_alarm_cmp`

## Requirements
- R1: After reset all alarm bytes read 0x00, the control/status byte reads 0x02 (flag clear, interrupt masked), and the interrupt request is low.
- R2: The minute and hour alarm bytes read back exactly as written. The day alarm byte keeps bit 7 and bits 2:0, and its bits 6:3 always read 0.
- R3: With bit 7 clear in all three alarm bytes, an evaluation sets the flag only when minutes bits 6:0, hours bits 6:0 and day bits 2:0 all equal the stored values.
- R4: With only the day byte's bit 7 set, an evaluation sets the flag when minutes and hours match, whatever the day.
- R5: With bit 7 set in the day and hour bytes, an evaluation sets the flag when minutes match, whatever the hour and day.
- R6: With bit 7 set in all three bytes, every evaluation sets the flag, which gives one alarm per seconds rollover from 59 to 00.
- R7: An evaluation happens only in a cycle where the hundredths-at-99 strobe and the seconds-rollover strobe are both high. A match without both strobes leaves the flag unchanged.
- R8: The flag (status bit 0) cannot be changed by a write to the control/status byte, and accessing that byte does not clear it.
- R9: A read or write strobe on select 0, 1 or 2 clears the flag. If the strobe falls in the same cycle as a matching evaluation, the flag stays clear and sets again only on a later evaluation.
- R10: The interrupt request, one clock after any state, equals flag AND NOT mask. The mask (status bit 1, writable) never changes the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 2 | Register select: 0 minute, 1 hour, 2 day, 3 control/status |
| reg_rd | input | 1 | Read strobe (counts as an access) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD with 12/24 and AM/PM bits |
| cur_day | input | 3 | Current day of week |
| hund99_stb | input | 1 | Hundredths count reads 99 |
| sec_roll_stb | input | 1 | Seconds roll from 59 to 00 in this step |
| alarm_irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is a read strobe on an alarm byte that lands in the same cycle as a matching evaluation. The clear must win, and the match must reappear at the next evaluation. The bench raises both strobes together with a matching time and a read of the minute byte on one clock edge. It then repeats the evaluation alone. The other hard cases are these: checking that status reads do not clear the flag, and unmasking while the flag is already set. The bench observes them by peeking at the status byte through the combinational read path with no strobe.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int BYTE_W    = 8;
  localparam int DAY_W     = 3;
  localparam int SEL_W     = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_MIN  = 2'd0,
    SEL_HOUR = 2'd1,
    SEL_DAY  = 2'd2,
    SEL_CTRL = 2'd3
  } alm_sel_e;
endpackage

// File: rtl/tod_alarm_rst_sync.sv
module tod_alarm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[gi] <= 1'b0;
        else if (gi == 0) chain_q[gi] <= 1'b1;
        else chain_q[gi] <= chain_q[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
  import tod_alarm_pkg::*;
#(
  parameter int DW   = BYTE_W,
  parameter int DAYW = DAY_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic            reg_rd,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            flag,
  output logic [DW-1:0]   reg_rdata,
  output logic [DW-1:0]   min_alm,
  output logic [DW-1:0]   hour_alm,
  output logic            day_mask,
  output logic [DAYW-1:0] day_val,
  output logic            irq_mask,
  output logic            alm_access
);
  localparam int PAD_W = DW - 1 - DAYW;

  logic [DW-1:0]   min_q, min_d, hour_q, hour_d;
  logic            dmask_q, dmask_d, imask_q, imask_d;
  logic [DAYW-1:0] dval_q, dval_d;
  logic            wr_min, wr_hour, wr_day, wr_ctrl;

  always_comb begin
    wr_min  = reg_wr && (reg_sel == SEL_MIN);
    wr_hour = reg_wr && (reg_sel == SEL_HOUR);
    wr_day  = reg_wr && (reg_sel == SEL_DAY);
    wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    min_d   = wr_min  ? reg_wdata : min_q;
    hour_d  = wr_hour ? reg_wdata : hour_q;
    dmask_d = wr_day  ? reg_wdata[DW-1] : dmask_q;
    dval_d  = wr_day  ? reg_wdata[DAYW-1:0] : dval_q;
    imask_d = wr_ctrl ? reg_wdata[1] : imask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q   <= '0;
      hour_q  <= '0;
      dmask_q <= 1'b0;
      dval_q  <= '0;
      imask_q <= 1'b1;
    end else begin
      min_q   <= min_d;
      hour_q  <= hour_d;
      dmask_q <= dmask_d;
      dval_q  <= dval_d;
      imask_q <= imask_d;
    end
  end

  always_comb begin
    unique case (reg_sel)
      SEL_MIN:  reg_rdata = min_q;
      SEL_HOUR: reg_rdata = hour_q;
      SEL_DAY:  reg_rdata = {dmask_q, {PAD_W{1'b0}}, dval_q};
      default:  reg_rdata = {{(DW-2){1'b0}}, imask_q, flag};
    endcase
  end

  assign alm_access = (reg_rd || reg_wr) && (reg_sel != SEL_CTRL);
  assign min_alm    = min_q;
  assign hour_alm   = hour_q;
  assign day_mask   = dmask_q;
  assign day_val    = dval_q;
  assign irq_mask   = imask_q;
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
#(
  parameter int DW   = BYTE_W,
  parameter int DAYW = DAY_W
) (
  input  logic [DW-1:0]   min_alm,
  input  logic [DW-1:0]   hour_alm,
  input  logic            day_mask,
  input  logic [DAYW-1:0] day_val,
  input  logic [DW-2:0]   cur_min,
  input  logic [DW-2:0]   cur_hour,
  input  logic [DAYW-1:0] cur_day,
  output logic            hit
);
  logic min_ok, hour_ok, day_ok;

  always_comb begin
    min_ok  = min_alm[DW-1]  || (min_alm[DW-2:0]  == cur_min);
    hour_ok = hour_alm[DW-1] || (hour_alm[DW-2:0] == cur_hour);
    day_ok  = day_mask       || (day_val          == cur_day);
    hit     = min_ok && hour_ok && day_ok;
  end
endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic eval_stb,
  input  logic hit,
  input  logic clr,
  input  logic irq_mask,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d, irq_q, irq_d;

  always_comb begin
    if (clr)                  flag_d = 1'b0;
    else if (eval_stb && hit) flag_d = 1'b1;
    else                      flag_d = flag_q;
    irq_d = flag_q && !irq_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;
endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
  import tod_alarm_pkg::*;
#(
  parameter int DW          = BYTE_W,
  parameter int DAYW        = DAY_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [DW-2:0]    cur_min,
  input  logic [DW-2:0]    cur_hour,
  input  logic [DAYW-1:0]  cur_day,
  input  logic             hund99_stb,
  input  logic             sec_roll_stb,
  output logic             alarm_irq
);
  logic            rst_sync_n;
  logic [DW-1:0]   min_alm, hour_alm;
  logic            day_mask, irq_mask, alm_access, hit, flag;
  logic [DAYW-1:0] day_val;
  logic            eval_stb;

  assign eval_stb = hund99_stb && sec_roll_stb;

  tod_alarm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tod_alarm_regs #(.DW(DW), .DAYW(DAYW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_sel(reg_sel), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .flag(flag),
    .reg_rdata(reg_rdata), .min_alm(min_alm), .hour_alm(hour_alm),
    .day_mask(day_mask), .day_val(day_val), .irq_mask(irq_mask),
    .alm_access(alm_access)
  );

  tod_alarm_match #(.DW(DW), .DAYW(DAYW)) u_match (
    .min_alm(min_alm), .hour_alm(hour_alm), .day_mask(day_mask),
    .day_val(day_val), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_day(cur_day), .hit(hit)
  );

  tod_alarm_flag u_flag (
    .clk(clk), .rst_n(rst_sync_n), .eval_stb(eval_stb), .hit(hit),
    .clr(alm_access), .irq_mask(irq_mask), .flag(flag), .irq(alarm_irq)
  );
endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hund99_stb,
  input logic          sec_roll_stb,
  input logic [1:0]    reg_sel,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [DW-1:0] reg_rdata,
  input logic [DW-2:0] cur_min,
  input logic [DW-1:0] min_alm,
  input logic          hour_mask,
  input logic          day_mask,
  input logic          flag,
  input logic          irq_mask,
  input logic          alarm_irq
);
  logic acc, ev;
  assign acc = (reg_rd || reg_wr) && (reg_sel != 2'd3);
  assign ev  = hund99_stb && sec_roll_stb;

  p_day_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd2) |-> (reg_rdata[DW-2:3] == '0));

  p_min_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !acc && !flag && !min_alm[DW-1] && (cur_min != min_alm[DW-2:0])) |=> !flag);

  p_every_minute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !acc && min_alm[DW-1] && hour_mask && day_mask) |=> flag);

  p_flag_needs_eval_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(ev));

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev && !acc) |=> $stable(flag));

  p_access_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !flag);

  p_mask_blocks_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |=> !alarm_irq);

  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> $past(flag));
endmodule

bind tod_alarm_cmp tod_alarm_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .hund99_stb(hund99_stb),
  .sec_roll_stb(sec_roll_stb), .reg_sel(reg_sel), .reg_rd(reg_rd),
  .reg_wr(reg_wr), .reg_rdata(reg_rdata), .cur_min(cur_min),
  .min_alm(min_alm), .hour_mask(hour_alm[DW-1]), .day_mask(day_mask),
  .flag(flag), .irq_mask(irq_mask), .alarm_irq(alarm_irq)
);

// File: tb/tod_alarm_cmp_tb.sv
module tod_alarm_cmp_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [6:0] cur_min = 7'h00, cur_hour = 7'h00;
  logic [2:0] cur_day = 3'd0;
  logic       hund99_stb = 1'b0, sec_roll_stb = 1'b0;
  logic       alarm_irq;

  int    checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_alarm_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
    .hund99_stb(hund99_stb), .sec_roll_stb(sec_roll_stb),
    .alarm_irq(alarm_irq)
  );

  // Behavioural reference model of the register-visible state
  logic [7:0] m_min, m_hour, m_day;
  bit         m_flag, m_mask, m_irq, m_live;

  function automatic bit m_match();
    bit a, b, c;
    a = m_min[7]  || (m_min[6:0]  == cur_min);
    b = m_hour[7] || (m_hour[6:0] == cur_hour);
    c = m_day[7]  || (m_day[2:0]  == cur_day);
    return a && b && c;
  endfunction

  function automatic logic [7:0] m_rdata();
    case (reg_sel)
      2'd0: return m_min;
      2'd1: return m_hour;
      2'd2: return m_day;
      default: return {6'b0, m_mask, m_flag};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_min = 8'h00; m_hour = 8'h00; m_day = 8'h00;
      m_flag = 0; m_mask = 1; m_irq = 0; m_live = 0;
    end else begin
      bit acc, ev, nirq;
      acc  = (reg_rd || reg_wr) && reg_sel != 2'd3;
      ev   = hund99_stb && sec_roll_stb && m_match();
      nirq = m_flag && !m_mask;
      if (acc) m_flag = 0;
      else if (ev) m_flag = 1;
      if (reg_wr) begin
        case (reg_sel)
          2'd0: m_min  = reg_wdata;
          2'd1: m_hour = reg_wdata;
          2'd2: m_day  = reg_wdata & 8'h87;
          default: m_mask = reg_wdata[1];
        endcase
      end
      m_irq  = nirq;
      m_live = 1;
    end
  end

  // Per-cycle comparison against the model, after the edge has settled
  always @(posedge clk) begin
    #1;
    if (rst_n && m_live) begin
      checks++;
      if (reg_rdata !== m_rdata() || alarm_irq !== m_irq) begin
        errors++;
        $display("FAIL %s model compare: rdata=%h irq=%b expected rdata=%h irq=%b",
                 cur_req, reg_rdata, alarm_irq, m_rdata(), m_irq);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel);
    @(negedge clk);
    reg_sel = sel; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, input string req, input logic [7:0] exp);
    @(negedge clk);
    reg_sel = sel;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic eval(input logic [6:0] mi, input logic [6:0] hr, input logic [2:0] dy,
                      input bit h99, input bit sr, input bit with_rd);
    @(negedge clk);
    cur_min = mi; cur_hour = hr; cur_day = dy;
    hund99_stb = h99; sec_roll_stb = sr;
    if (with_rd) begin reg_sel = 2'd0; reg_rd = 1'b1; end
    @(negedge clk);
    hund99_stb = 1'b0; sec_roll_stb = 1'b0; reg_rd = 1'b0;
  endtask

  // status peek: flag in bit 0, mask in bit 1, then irq one edge later
  task automatic status(input string req, input logic [7:0] exp, input logic exp_irq);
    peek(2'd3, req, exp);
    chk(req, {7'b0, alarm_irq}, {7'b0, exp_irq});
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R1";
    peek(2'd0, "R1", 8'h00);
    peek(2'd1, "R1", 8'h00);
    peek(2'd2, "R1", 8'h00);
    status("R1", 8'h02, 1'b0);

    cur_req = "R2";
    wr_reg(2'd0, 8'h59);
    wr_reg(2'd1, 8'h23);
    wr_reg(2'd2, 8'hFF);
    peek(2'd0, "R2", 8'h59);
    peek(2'd1, "R2", 8'h23);
    peek(2'd2, "R2", 8'h87);
    wr_reg(2'd2, 8'h05);
    peek(2'd2, "R2", 8'h05);

    cur_req = "R8";
    wr_reg(2'd3, 8'h03);
    status("R8", 8'h02, 1'b0);
    wr_reg(2'd3, 8'h01);
    status("R8", 8'h00, 1'b0);

    cur_req = "R7";
    eval(7'h59, 7'h23, 3'd5, 1'b1, 1'b0, 1'b0);
    status("R7", 8'h00, 1'b0);
    eval(7'h59, 7'h23, 3'd5, 1'b0, 1'b1, 1'b0);
    status("R7", 8'h00, 1'b0);

    cur_req = "R3";
    eval(7'h59, 7'h23, 3'd4, 1'b1, 1'b1, 1'b0);
    status("R3", 8'h00, 1'b0);
    eval(7'h58, 7'h23, 3'd5, 1'b1, 1'b1, 1'b0);
    status("R3", 8'h00, 1'b0);
    eval(7'h59, 7'h23, 3'd5, 1'b1, 1'b1, 1'b0);
    status("R3", 8'h01, 1'b1);

    cur_req = "R8";
    rd_reg(2'd3);
    status("R8", 8'h01, 1'b1);

    cur_req = "R9";
    rd_reg(2'd0);
    status("R9", 8'h00, 1'b0);

    cur_req = "R10";
    wr_reg(2'd3, 8'h02);
    eval(7'h59, 7'h23, 3'd5, 1'b1, 1'b1, 1'b0);
    status("R10", 8'h03, 1'b0);
    wr_reg(2'd3, 8'h00);
    status("R10", 8'h01, 1'b1);
    wr_reg(2'd1, 8'h23);
    status("R9", 8'h00, 1'b0);

    cur_req = "R4";
    wr_reg(2'd2, 8'h85);
    eval(7'h59, 7'h23, 3'd2, 1'b1, 1'b1, 1'b0);
    status("R4", 8'h01, 1'b1);
    rd_reg(2'd2);
    eval(7'h59, 7'h22, 3'd2, 1'b1, 1'b1, 1'b0);
    status("R4", 8'h00, 1'b0);

    cur_req = "R5";
    wr_reg(2'd1, 8'hA3);
    eval(7'h59, 7'h07, 3'd1, 1'b1, 1'b1, 1'b0);
    status("R5", 8'h01, 1'b1);
    rd_reg(2'd1);
    eval(7'h58, 7'h07, 3'd1, 1'b1, 1'b1, 1'b0);
    status("R5", 8'h00, 1'b0);

    cur_req = "R6";
    wr_reg(2'd0, 8'hD9);
    eval(7'h12, 7'h45, 3'd6, 1'b1, 1'b1, 1'b0);
    status("R6", 8'h01, 1'b1);
    wr_reg(2'd0, 8'hD9);
    eval(7'h13, 7'h45, 3'd6, 1'b1, 1'b1, 1'b0);
    status("R6", 8'h01, 1'b1);

    cur_req = "R9";
    rd_reg(2'd0);
    eval(7'h14, 7'h45, 3'd6, 1'b1, 1'b1, 1'b1);
    status("R9", 8'h00, 1'b0);
    eval(7'h15, 7'h45, 3'd6, 1'b1, 1'b1, 1'b0);
    status("R9", 8'h01, 1'b1);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule